// File: doc/BRIEF.md
# Four-Channel Interval Timer PWM

This peripheral holds four independent timer channels, each able to produce a pulse-width-modulated output. Software reaches it over a simple 32-bit register bus: one shared enable word, plus a control word and a reload word per channel. A running channel drives its output high for a programmed number of ticks, then low for a second programmed number, and repeats that pattern until it is disabled.

Each channel picks its own count clock. It can count every bus clock cycle, or count the rising edges of a slow external clock. That external clock is brought into the bus domain by a short synchroniser chain and an edge detector. Both phase lengths live in a single reload word. A new reload value written while a channel runs is held back until the current period ends, so no period is ever cut short.

Top module: `pit_pwm_top`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and drives all four PWM outputs low.
- R2: Register layout, all at byte offsets on a 4-byte stride. The enable word is at 0x1C, and bit 3+4n enables channel n. The control word of channel n is at 0x20+0x10n; it keeps bits 4:0 and reads zero above them. The reload word of channel n is at 0x24+0x10n. The enable and reload words read back all 32 bits last written.
- R3: A channel runs only when its enable bit is set and bits 2:0 of its control word equal 4 (PWM mode). In any other case its output stays low.
- R4: Reload bits 31:16 give the high value H and bits 15:0 give the low value L. A running channel is high for H+1 ticks and then low for L+1 ticks, and this repeats. An enabled channel starts at the beginning of a high phase.
- R5: Control bit 3 set to 1 makes the channel tick on every bus clock cycle. Set to 0, the channel ticks once per rising edge of the external clock, after a two-flop synchroniser; each such edge gives a one-cycle tick.
- R6: Clearing a channel's enable bit drives its output low in the first cycle after the write and resets its counter. Enabling it again starts a full high phase.
- R7: A reload write made while a channel runs takes effect only at the next period boundary (the end of a low phase). The period in progress completes with the old lengths.
- R8: A read of an unmapped or misaligned offset returns zero. A write to one changes no register and no output.
- R9: Channels are independent. Each channel uses its own clock source and lengths, and one channel's activity does not change another's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Slow external count clock, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
The bench measures whole run lengths at the outputs. The extreme value H=L=0 gives a one-cycle toggle, and an off-by-one in the terminal compare would stretch or shrink every phase. A reload written partway through a high phase must leave that high phase and the following low phase at their old lengths; a design that loads reload values directly would cut the current period short. Disabling a channel during its low phase and enabling it again must give a full first high phase; a counter left uncleared would give a short one. A channel on the external clock must show phases that are exact multiples of the external period while a bus-clocked neighbour keeps toggling, which exposes a missing edge detector or a shared tick.

// File: rtl/pit_pwm_pkg.sv
package pit_pwm_pkg;

    localparam int NUM_CH      = 4;
    localparam int DATA_W      = 32;
    localparam int HALF_W      = DATA_W / 2;
    localparam int CTRL_W      = 5;
    localparam int EN_OFF      = 32'h1C;
    localparam int CTRL_BASE   = 32'h20;
    localparam int RELOAD_BASE = 32'h24;
    localparam int CH_STRIDE   = 32'h10;
    localparam int CLKSEL_BIT  = 3;
    localparam logic [2:0] MODE_PWM = 3'd4;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } phase_len_t;

    typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;

    function automatic int en_bit(input int ch);
        return 3 + 4 * ch;
    endfunction

    function automatic logic [31:0] ctrl_off(input int ch);
        return 32'(CTRL_BASE + CH_STRIDE * ch);
    endfunction

    function automatic logic [31:0] reload_off(input int ch);
        return 32'(RELOAD_BASE + CH_STRIDE * ch);
    endfunction

endpackage

// File: rtl/pit_pwm_tick_sync.sv
module pit_pwm_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    output logic tick_o
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk};
    end

    assign tick_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

    // R5
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/pit_pwm_channel.sv
module pit_pwm_channel
    import pit_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active_i,
    input  logic       tick_i,
    input  phase_len_t reload_i,
    output logic       pwm_o
);
    logic              run_q;
    phase_e            ph_q;
    logic [HALF_W-1:0] cnt_q;
    phase_len_t        shadow_q;
    logic              at_end;
    logic              wrap;

    assign at_end = (ph_q == PH_HIGH) ? (cnt_q == shadow_q.hi) : (cnt_q == shadow_q.lo);
    assign wrap   = run_q && tick_i && (ph_q == PH_LOW) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            ph_q     <= PH_HIGH;
            cnt_q    <= '0;
            shadow_q <= '0;
        end else if (!active_i) begin
            run_q <= 1'b0;
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
        end else if (!run_q) begin
            run_q    <= 1'b1;
            ph_q     <= PH_HIGH;
            cnt_q    <= '0;
            shadow_q <= reload_i;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_q <= '0;
                if (ph_q == PH_HIGH) begin
                    ph_q <= PH_LOW;
                end else begin
                    ph_q     <= PH_HIGH;
                    shadow_q <= reload_i;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pwm_o = active_i & run_q & (ph_q == PH_HIGH);

    // R6
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> !run_q && !pwm_o);
    // R4
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> (ph_q == PH_HIGH) && (cnt_q == '0));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> cnt_q <= ((ph_q == PH_HIGH) ? shadow_q.hi : shadow_q.lo));
    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$past(wrap)) |-> $stable(shadow_q));

endmodule

// File: rtl/pit_pwm_top.sv
module pit_pwm_top
    import pit_pwm_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   pwm_o
);
    logic [31:0]       addr_ext;
    logic              wr_en;
    logic [DATA_W-1:0] en_q;
    logic [CTRL_W-1:0] ctrl_q   [N_CH];
    phase_len_t        reload_q [N_CH];
    logic              ext_tick;

    assign addr_ext = 32'(bus_addr);
    assign wr_en    = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        if (rst)                              en_q <= '0;
        else if (wr_en && addr_ext == EN_OFF) en_q <= bus_wdata;
    end

    pit_pwm_tick_sync #(.SYNC_STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ext_clk(ext_clk),
        .tick_o (ext_tick)
    );

    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        logic active;
        logic tick;

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[n]   <= '0;
                reload_q[n] <= '0;
            end else if (wr_en) begin
                if (addr_ext == ctrl_off(n))   ctrl_q[n]   <= bus_wdata[CTRL_W-1:0];
                if (addr_ext == reload_off(n)) reload_q[n] <= bus_wdata;
            end
        end

        assign active = en_q[en_bit(n)] && (ctrl_q[n][2:0] == MODE_PWM);
        assign tick   = ctrl_q[n][CLKSEL_BIT] ? 1'b1 : ext_tick;

        pit_pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .active_i(active),
            .tick_i  (tick),
            .reload_i(reload_q[n]),
            .pwm_o   (pwm_o[n])
        );

        // R3
        mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
            !(en_q[en_bit(n)] && ctrl_q[n][2:0] == MODE_PWM) |-> !pwm_o[n]);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (addr_ext == EN_OFF) bus_rdata = en_q;
            for (int n = 0; n < N_CH; n++) begin
                if (addr_ext == ctrl_off(n))   bus_rdata = DATA_W'(ctrl_q[n]);
                if (addr_ext == reload_off(n)) bus_rdata = reload_q[n];
            end
        end
    end

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (pwm_o == '0) && (en_q == '0));
    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);

endmodule

// File: tb/pit_pwm_top_tb.sv
module pit_pwm_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;
    always #20 ext_clk = ~ext_clk;

    pit_pwm_top u_dut (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
    );

    // run-length log per channel, sampled at negedge
    int run_len [4][16];
    bit run_lvl [4][16];
    int run_n   [4];
    int cur     [4];
    bit prv     [4];
    bit log_clr = 1'b0;

    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (log_clr) begin
                run_n[c] = 0; cur[c] = 1; prv[c] = pwm_o[c];
            end else if (pwm_o[c] == prv[c]) begin
                cur[c] = cur[c] + 1;
            end else begin
                if (run_n[c] < 16) begin
                    run_len[c][run_n[c]] = cur[c];
                    run_lvl[c][run_n[c]] = prv[c];
                    run_n[c] = run_n[c] + 1;
                end
                cur[c] = 1; prv[c] = pwm_o[c];
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic clr_log();
        @(negedge clk); #1 log_clr = 1'b1;
        @(negedge clk); #1 log_clr = 1'b0;
    endtask

    function automatic int first_high(input int c);
        for (int k = 0; k < 16; k++)
            if (k < run_n[c] && run_lvl[c][k]) return k;
        return 12;
    endfunction

    // ch, hi, lo
    localparam logic [33:0] VECS [5] = '{
        {2'd0, 16'd9, 16'd19},
        {2'd1, 16'd0, 16'd0},
        {2'd2, 16'd1, 16'd0},
        {2'd3, 16'd0, 16'd5},
        {2'd2, 16'd4, 16'd4}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int k;
        int highs;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 outputs during reset", 32'(pwm_o), 0);
        rst = 1'b0;
        rd(8'h1C, d); chk("R1 enable after reset", d, 0);
        rd(8'h24, d); chk("R1 reload0 after reset", d, 0);
        rd(8'h50, d); chk("R1 ctrl3 after reset", d, 0);

        // R2 readback
        wr(8'h34, 32'hDEAD_BEEF); rd(8'h34, d); chk("R2 reload1 readback", d, 32'hDEAD_BEEF);
        wr(8'h40, 32'hFFFF_FFE4); rd(8'h40, d); chk("R2 ctrl2 keeps 5 bits", d, 32'h04);
        wr(8'h1C, 32'hA5A5_0000); rd(8'h1C, d); chk("R2 enable readback", d, 32'hA5A5_0000);
        wr(8'h1C, 0);

        // R8 unmapped / misaligned
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); chk("R8 unmapped read", d, 0);
        wr(8'h1D, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R8 misaligned write ignored", d, 0);
        rd(8'h28, d); chk("R8 gap read", d, 0);
        repeat (4) @(negedge clk);
        chk("R8 outputs idle after stray writes", 32'(pwm_o), 0);

        // R4/R5 vector table, bus clock
        for (int v = 0; v < 5; v++) begin
            int c;
            int h;
            int l;
            c = int'(VECS[v][33:32]); h = int'(VECS[v][31:16]); l = int'(VECS[v][15:0]);
            wr(8'h1C, 0);
            wr(8'(32'h20 + 16 * c), 32'h0C);
            wr(8'(32'h24 + 16 * c), {VECS[v][31:16], VECS[v][15:0]});
            clr_log();
            wr(8'h1C, 32'h1 << (3 + 4 * c));
            repeat (3 * (h + l + 2) + 10) @(negedge clk);
            chk("R9 other channels idle", 32'(pwm_o & ~(4'h1 << c)), 0);
            k = first_high(c);
            chk("R4 first high run", run_len[c][k], h + 1);
            chk("R4 low run", run_len[c][k+1], l + 1);
            chk("R5 bus clock second high run", run_len[c][k+2], h + 1);
        end
        wr(8'h1C, 0);

        // R3 mode not PWM
        wr(8'h20, 32'h08); wr(8'h24, 0); wr(8'h1C, 32'h8);
        highs = 0;
        repeat (40) begin @(negedge clk); if (pwm_o[0]) highs++; end
        chk("R3 non-PWM mode stays low", highs, 0);
        wr(8'h20, 32'h0C);
        highs = 0;
        repeat (20) begin @(negedge clk); if (pwm_o[0]) highs++; end
        chk("R3 PWM mode toggles", highs, 10);
        wr(8'h1C, 0);

        // R7 reload during run
        wr(8'h24, {16'd9, 16'd19});
        clr_log();
        wr(8'h1C, 32'h8);
        @(negedge clk); while (!pwm_o[0]) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(8'h24, {16'd2, 16'd3});
        repeat (60) @(negedge clk);
        k = first_high(0);
        chk("R7 current high keeps old length", run_len[0][k], 10);
        chk("R7 current low keeps old length", run_len[0][k+1], 20);
        chk("R7 new high after boundary", run_len[0][k+2], 3);
        chk("R7 new low after boundary", run_len[0][k+3], 4);

        // R6 disable mid-high, low at once
        wr(8'h1C, 0); wr(8'h24, {16'd9, 16'd19}); wr(8'h1C, 32'h8);
        @(negedge clk); while (!pwm_o[0]) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(8'h1C, 0);
        chk("R6 output low after disable", 32'(pwm_o[0]), 0);
        // R6 disable during low, restart full high
        wr(8'h1C, 32'h8);
        @(negedge clk); while (!pwm_o[0]) @(negedge clk);
        repeat (15) @(negedge clk);
        chk("R6 in low phase", 32'(pwm_o[0]), 0);
        wr(8'h1C, 0);
        clr_log();
        wr(8'h1C, 32'h8);
        repeat (50) @(negedge clk);
        k = first_high(0);
        chk("R6 restart full high", run_len[0][k], 10);
        chk("R6 restart full low", run_len[0][k+1], 20);
        wr(8'h1C, 0);

        // R5/R9 external clock on ch1, bus clock on ch0
        wr(8'h24, 0); wr(8'h20, 32'h0C);
        wr(8'h34, {16'd1, 16'd0}); wr(8'h30, 32'h04);
        clr_log();
        wr(8'h1C, 32'h88);
        repeat (300) @(negedge clk);
        k = first_high(1);
        chk("R5 ext low one tick", run_len[1][k+1], 10);
        chk("R5 ext high two ticks", run_len[1][k+2], 20);
        chk("R5 ext low again", run_len[1][k+3], 10);
        k = first_high(0);
        chk("R9 bus channel beside ext channel high", run_len[0][k], 1);
        chk("R9 bus channel beside ext channel low", run_len[0][k+1], 1);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 outputs after reset", 32'(pwm_o), 0);
        rd(8'h34, d); chk("R1 reload1 cleared", d, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule